// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single line. A host places a character into a one-entry holding register whenever the ready flag says the register is free. A frame shifter takes the character from that register and sends a start bit, the data bits least significant first, an optional parity bit and one or two stop bits. The baud generator supplies a single-cycle bit strobe, and every bit of a frame occupies exactly one strobe interval.

The holding register passes its character to the shifter on a strobe cycle, in one of two cases: the shifter is idle, or that strobe ends the final stop bit of the frame in progress. A host that refills the holding register as soon as the ready flag returns therefore gets frames with no idle time between them. The frame shape comes from three configuration inputs, which the shifter samples at the moment of handoff. A transmit enable decides whether the block owns the pin. When the enable is low, the output-enable drops, the line rests high and the shifter stays idle.

Top module: `uart_tx_dbuf`

## Requirements
- R1: With the transmitter enabled and no character pending, `txd_out` stays at 1 and `txd_oe` is 1.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the parity bit if enabled, then stop bits at 1.
- R3: `cfg_size` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected count are not sent.
- R4: `cfg_parity` 10 appends even parity and 11 appends odd parity, both computed over the sent data bits only. Codes 00 and 01 send no parity bit.
- R5: `cfg_two_stop` = 0 sends one stop bit and 1 sends two.
- R6: `txd_out` changes only on the clock edge at which `baud_tick` is 1, so each bit lasts one strobe interval.
- R7: The held character moves into the shifter on a strobe when the shifter is idle, or on the strobe that ends the last stop bit. In the second case the next start bit follows the previous stop bit with no gap.
- R8: `buf_empty` is 1 after reset. It goes to 0 on the edge that accepts a host write, and returns to 1 on the edge of the handoff.
- R9: A write while `buf_empty` is 0 is discarded and never sent.
- R10: While `tx_en` is 0, `txd_oe` is 0 from the next edge, `txd_out` is 1, and no handoff occurs. A character written in that time is held and sent once `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; gives the block ownership of the pin |
| baud_tick | input | 1 | One-cycle bit strobe from the baud generator |
| wr_valid | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Character to be sent |
| cfg_size | input | 2 | Data-length code (5 to 8 bits) |
| cfg_parity | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | Stop-bit count select |
| buf_empty | output | 1 | Holding register can accept a character |
| txd_out | output | 1 | Serial output line |
| txd_oe | output | 1 | Output-enable for the pin driver |

## Verification
The bench builds the block with its default 8-bit character path and raises the strobe on every fifth clock. At that rate a stop bit and the next start bit are easy to tell apart, and a full 12-bit frame completes in about sixty cycles. The vector table covers all four length codes, all four parity codes and both stop counts, including upper data bits that must be dropped. Directed sequences cover back-to-back handoff, a rejected write into a full register, and a character parked while the transmitter is disabled.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int unsigned CHAR_W   = 8;
    localparam int unsigned CNT_W    = $clog2(CHAR_W + 1);
    localparam int unsigned MIN_CHAR = 5;

    typedef enum logic [1:0] {
        SZ_5 = 2'b00,
        SZ_6 = 2'b01,
        SZ_7 = 2'b10,
        SZ_8 = 2'b11
    } char_size_e;

    typedef enum logic [1:0] {
        PM_NONE = 2'b00,
        PM_RSVD = 2'b01,
        PM_EVEN = 2'b10,
        PM_ODD  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP1,
        PH_STOP2
    } phase_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        char_size_e        size;
        par_mode_e         par;
        logic              two_stop;
    } frame_t;

    function automatic logic [CNT_W-1:0] char_bits(input char_size_e s);
        return CNT_W'(MIN_CHAR) + CNT_W'(s);
    endfunction

    function automatic logic parity_on(input par_mode_e p);
        return (p == PM_EVEN) || (p == PM_ODD);
    endfunction

    function automatic logic calc_parity(input logic [CHAR_W-1:0] d,
                                         input char_size_e s,
                                         input par_mode_e p);
        logic             acc;
        logic [CNT_W-1:0] n;
        acc = 1'b0;
        n   = char_bits(s);
        for (int i = 0; i < CHAR_W; i++) begin
            if (CNT_W'(i) < n) acc = acc ^ d[i];
        end
        return (p == PM_ODD) ? ~acc : acc;
    endfunction

endpackage

// File: rtl/utx_holdbuf.sv
module utx_holdbuf
    import utx_pkg::*;
#(
    parameter int unsigned W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         empty,
    output logic [W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            empty <= 1'b1;
            data  <= '0;
        end else if (take) begin
            empty <= 1'b1;
        end else if (wr_valid && empty) begin
            empty <= 1'b0;
            data  <= wr_data;
        end
    end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   tick,
    input  logic   pend,
    input  frame_t nxt,
    output logic   take,
    output logic   line
);

    phase_e            ph;
    logic [CHAR_W-1:0] sh;
    logic [CNT_W-1:0]  left;
    logic              par_q;
    logic              par_en;
    logic              two_q;
    logic              last_stop;

    always_comb begin
        last_stop = ((ph == PH_STOP1) && !two_q) || (ph == PH_STOP2);
        take      = enable && tick && pend && ((ph == PH_IDLE) || last_stop);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            ph     <= PH_IDLE;
            line   <= 1'b1;
            sh     <= '0;
            left   <= '0;
            par_q  <= 1'b0;
            par_en <= 1'b0;
            two_q  <= 1'b0;
        end else if (tick) begin
            if (take) begin
                ph     <= PH_START;
                line   <= 1'b0;
                sh     <= nxt.data;
                left   <= char_bits(nxt.size);
                par_q  <= calc_parity(nxt.data, nxt.size, nxt.par);
                par_en <= parity_on(nxt.par);
                two_q  <= nxt.two_stop;
            end else begin
                unique case (ph)
                    PH_IDLE: begin
                        line <= 1'b1;
                    end
                    PH_START: begin
                        ph   <= PH_DATA;
                        line <= sh[0];
                        sh   <= sh >> 1;
                        left <= left - 1'b1;
                    end
                    PH_DATA: begin
                        if (left != '0) begin
                            line <= sh[0];
                            sh   <= sh >> 1;
                            left <= left - 1'b1;
                        end else if (par_en) begin
                            ph   <= PH_PAR;
                            line <= par_q;
                        end else begin
                            ph   <= PH_STOP1;
                            line <= 1'b1;
                        end
                    end
                    PH_PAR: begin
                        ph   <= PH_STOP1;
                        line <= 1'b1;
                    end
                    PH_STOP1: begin
                        ph   <= two_q ? PH_STOP2 : PH_IDLE;
                        line <= 1'b1;
                    end
                    PH_STOP2: begin
                        ph   <= PH_IDLE;
                        line <= 1'b1;
                    end
                    default: begin
                        ph   <= PH_IDLE;
                        line <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              wr_valid,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic [1:0]        cfg_size,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    output logic              buf_empty,
    output logic              txd_out,
    output logic              txd_oe
);

    logic              take;
    logic [CHAR_W-1:0] hold_data;
    frame_t            nxt;

    utx_holdbuf #(.W(CHAR_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .empty    (buf_empty),
        .data     (hold_data)
    );

    always_comb begin
        nxt.data     = hold_data;
        nxt.size     = char_size_e'(cfg_size);
        nxt.par      = par_mode_e'(cfg_parity);
        nxt.two_stop = cfg_two_stop;
    end

    utx_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .enable (tx_en),
        .tick   (baud_tick),
        .pend   (!buf_empty),
        .nxt    (nxt),
        .take   (take),
        .line   (txd_out)
    );

    always_ff @(posedge clk) begin
        if (rst) txd_oe <= 1'b0;
        else     txd_oe <= tx_en;
    end

endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic baud_tick,
    input logic wr_valid,
    input logic buf_empty,
    input logic txd_out,
    input logic txd_oe
);

    assert_line_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !baud_tick) |=> $stable(txd_out));

    assert_write_fills_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && buf_empty) |=> !buf_empty);

    assert_handoff_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_empty) |-> ($past(baud_tick) && $past(tx_en)));

    assert_full_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!buf_empty && !baud_tick) |=> !buf_empty);

    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (!txd_oe && txd_out));

endmodule

bind uart_tx_dbuf utx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .baud_tick (baud_tick),
    .wr_valid  (wr_valid),
    .buf_empty (buf_empty),
    .txd_out   (txd_out),
    .txd_oe    (txd_oe)
);

// File: tb/sim_uart_tx_dbuf.sv
module sim_uart_tx_dbuf;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_size = 2'b11;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic       buf_empty;
    logic       txd_out;
    logic       txd_oe;

    int checks = 0;
    int fails  = 0;
    int tdiv   = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tdiv      <= (tdiv == 4) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == 4);
    end

    uart_tx_dbuf u0 (
        .clk          (clk),
        .rst          (rst),
        .tx_en        (tx_en),
        .baud_tick    (baud_tick),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .cfg_size     (cfg_size),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .buf_empty    (buf_empty),
        .txd_out      (txd_out),
        .txd_oe       (txd_oe)
    );

    // {data[12:5], size[4:3], parity[2:1], two_stop[0]}
    localparam logic [12:0] VEC [7] = '{
        {8'hA5, 2'b11, 2'b00, 1'b0},
        {8'h3C, 2'b11, 2'b10, 1'b0},
        {8'h3C, 2'b11, 2'b11, 1'b1},
        {8'hFF, 2'b00, 2'b10, 1'b0},
        {8'h5A, 2'b01, 2'b11, 1'b0},
        {8'h81, 2'b10, 2'b00, 1'b1},
        {8'hC0, 2'b11, 2'b01, 1'b0}
    };

    task automatic check(input bit cond, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [1:0] sz,
                                              input logic [1:0] pm, input logic st,
                                              output int len);
        logic [11:0] b;
        logic        p;
        int          nb;
        int          pos;
        b   = '1;
        b[0] = 1'b0;
        p   = 1'b0;
        nb  = 5 + int'(sz);
        for (int i = 0; i < nb; i++) begin
            b[1+i] = d[i];
            p      = p ^ d[i];
        end
        pos = 1 + nb;
        if (pm[1]) begin
            b[pos] = pm[0] ? ~p : p;
            pos++;
        end
        len = pos + 1 + int'(st);
        return b;
    endfunction

    task automatic sample_bit(output logic b);
        @(posedge clk);
        while (!baud_tick) @(posedge clk);
        @(negedge clk);
        b = txd_out;
    endtask

    task automatic capture(input int n, output logic [11:0] got);
        logic b;
        int   k;
        got = '1;
        b   = 1'b1;
        k   = 0;
        while (b && k < 40) begin
            sample_bit(b);
            k++;
        end
        got[0] = b;
        for (int i = 1; i < n; i++) begin
            sample_bit(b);
            got[i] = b;
        end
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        while (!buf_empty) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        check(buf_empty == 1'b0, "R8 flag clears after write", 32'(buf_empty), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [11:0] got;
        logic [11:0] exp;
        logic [11:0] got2;
        logic [11:0] exp2;
        logic        b;
        int          len;
        int          len2;
        int          viol;
        logic        t;
        logic        last;

        repeat (5) @(negedge clk);
        check(buf_empty == 1'b1, "R8 reset flag", 32'(buf_empty), 1);
        check(txd_oe == 1'b0, "R10 reset oe", 32'(txd_oe), 0);
        check(txd_out == 1'b1, "R1 reset line", 32'(txd_out), 1);
        rst   = 1'b0;
        tx_en = 1'b1;
        repeat (3) @(negedge clk);
        check(txd_oe == 1'b1, "R1 oe when enabled", 32'(txd_oe), 1);
        viol = 0;
        for (int i = 0; i < 4; i++) begin
            sample_bit(b);
            if (b !== 1'b1) viol++;
        end
        check(viol == 0, "R1 idle line high", 32'(viol), 0);

        // table of frame shapes: R2 R3 R4 R5
        for (int v = 0; v < 7; v++) begin
            @(negedge clk);
            cfg_size     = VEC[v][4:3];
            cfg_parity   = VEC[v][2:1];
            cfg_two_stop = VEC[v][0];
            exp = exp_frame(VEC[v][12:5], VEC[v][4:3], VEC[v][2:1], VEC[v][0], len);
            host_write(VEC[v][12:5]);
            capture(len, got);
            check(got == exp, $sformatf("R2 R3 R4 R5 frame vector %0d", v), 32'(got), 32'(exp));
            repeat (3) sample_bit(b);
        end

        // R7 back-to-back handoff, 8N1
        @(negedge clk);
        cfg_size = 2'b11; cfg_parity = 2'b00; cfg_two_stop = 1'b0;
        exp  = exp_frame(8'h55, 2'b11, 2'b00, 1'b0, len);
        exp2 = exp_frame(8'h0F, 2'b11, 2'b00, 1'b0, len2);
        fork
            begin
                capture(len, got);
                got2 = '1;
                sample_bit(b);
                got2[0] = b;
                check(buf_empty == 1'b1, "R8 flag sets at handoff", 32'(buf_empty), 1);
                for (int i = 1; i < len2; i++) begin
                    sample_bit(b);
                    got2[i] = b;
                end
            end
            begin
                host_write(8'h55);
                host_write(8'h0F);
            end
        join
        check(got == exp, "R7 first frame", 32'(got), 32'(exp));
        check(got2 == exp2, "R7 second frame with no gap", 32'(got2), 32'(exp2));
        repeat (3) sample_bit(b);

        // R9 write into a full register is dropped
        exp  = exp_frame(8'h33, 2'b11, 2'b00, 1'b0, len);
        exp2 = exp_frame(8'h99, 2'b11, 2'b00, 1'b0, len2);
        fork
            begin
                capture(len, got);
                capture(len2, got2);
            end
            begin
                host_write(8'h33);
                host_write(8'h99);
                wr_valid = 1'b1;
                wr_data  = 8'hE7;
                @(negedge clk);
                wr_valid = 1'b0;
            end
        join
        check(got == exp && got2 == exp2, "R9 accepted frames", 32'({got, got2}), 32'({exp, exp2}));
        viol = 0;
        for (int i = 0; i < 12; i++) begin
            sample_bit(b);
            if (b !== 1'b1) viol++;
        end
        check(viol == 0, "R9 dropped char not sent", 32'(viol), 0);
        check(buf_empty == 1'b1, "R9 flag after drop", 32'(buf_empty), 1);

        // R6 line changes only on strobe edges
        host_write(8'h55);
        viol = 0;
        last = txd_out;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk);
            t = baud_tick;
            @(negedge clk);
            if (!t && txd_out !== last) viol++;
            last = txd_out;
        end
        check(viol == 0, "R6 off-strobe changes", 32'(viol), 0);
        repeat (12) sample_bit(b);

        // R10 disable releases pin and parks the character
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        check(txd_oe == 1'b0 && txd_out == 1'b1, "R10 released", 32'({txd_oe, txd_out}), 32'b01);
        host_write(8'hC3);
        viol = 0;
        for (int i = 0; i < 6; i++) begin
            sample_bit(b);
            if (b !== 1'b1) viol++;
        end
        check(viol == 0 && buf_empty == 1'b0, "R10 no handoff while disabled",
              32'({viol[7:0], buf_empty}), 0);
        exp = exp_frame(8'hC3, 2'b11, 2'b00, 1'b0, len);
        tx_en = 1'b1;
        capture(len, got);
        check(got == exp, "R10 parked char sent after enable", 32'(got), 32'(exp));
        check(txd_oe == 1'b1, "R10 oe back", 32'(txd_oe), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule